// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands one bit position per clock. It uses two shift registers, one full adder and one carry flip-flop. The operands go into the accumulator register A and the addend register B through a parallel load. Each enabled step feeds the full adder with the low bit of A, the low bit of B and the stored carry. The step then shifts both registers one place toward the LSB. The sum bit enters A at its MSB end, and the carry-out is captured in the carry flip-flop. After WIDTH enabled steps, A holds the sum and the carry flip-flop holds the final carry.

While an addition runs, register B takes new bits at its MSB end from a serial input, so the next addend can stream in during the current addition. A step enable gates every register, including the carry flip-flop, and the sequence pauses whenever the enable is low. A synchronous clear sets the carry to zero before a new addition.

All pins are plain level controls and data words. There is no streaming handshake: the caller owns the step count, so a valid/ready pair would add logic without adding meaning.

Top module: `serial_adder_top`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, `acc_q`, `addend_q` and `carry_q` are all zero.
- R2: When `load` is 1 at a clock edge, `acc_q` takes `acc_init` and `addend_q` takes `addend_init`, whatever the value of `step_en`. The load leaves `carry_q` unchanged.
- R3: When `load` is 0 and `step_en` is 1 at a clock edge, `acc_q` becomes {sum, acc_q[WIDTH-1:1]}, where sum is acc_q[0] XOR addend_q[0] XOR carry_q. `carry_q` takes the majority of those three bits, unless R5 applies.
- R4: When `load`, `step_en` and `carry_clr` are all 0 at a clock edge, `acc_q`, `addend_q` and `carry_q` keep their values.
- R5: When `carry_clr` is 1 at a clock edge, `carry_q` becomes 0. This overrides the carry update of R3, and `acc_q` and `addend_q` still follow R2, R3 or R4.
- R6: After a load, a clear and then WIDTH enabled steps, `acc_q` equals (A + B) mod 2^WIDTH and `carry_q` equals bit WIDTH of A + B. Two examples: 1000 + 0101 gives 1101 with carry 0, and 1011 + 0101 gives 0000 with carry 1. If the carry is not cleared, the carry left from the previous addition is added in as a carry-in.
- R7: Each enabled, non-load step shifts `addend_q` one place toward the LSB and places `addend_sin` in bit WIDTH-1. After WIDTH steps, the bit fed first sits in bit 0.
- R8: `sum_bit` equals acc_q[0] XOR addend_q[0] XOR carry_q at all times, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Parallel load of both operand registers |
| acc_init | input | WIDTH | Value loaded into the accumulator register A |
| addend_init | input | WIDTH | Value loaded into the addend register B |
| step_en | input | 1 | Enables one shift-and-add step |
| carry_clr | input | 1 | Synchronous clear of the carry flip-flop |
| addend_sin | input | 1 | Serial input at the MSB end of B |
| acc_q | output | WIDTH | Accumulator contents; holds the sum when done |
| addend_q | output | WIDTH | Addend register contents |
| carry_q | output | 1 | Carry flip-flop |
| sum_bit | output | 1 | Current full-adder sum bit |

## Verification
The bench checks operand pairs whose sum overflows, where a design that dropped or misrouted the carry would leave the wrong top bits and a wrong final carry. It checks a load without a clear after an addition that ended with a carry, which exposes a load that also clears the carry or a carry that leaks in the wrong direction. It pauses an addition in the middle to catch registers or a carry that advance while the enable is low. It checks a clear issued during a step that would otherwise produce a carry, and streams a pattern into B to catch reversed bit order or a serial input landing at the wrong end.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;
  localparam int unsigned DEFAULT_WIDTH = 4;

  typedef struct packed {
    logic sum;
    logic cout;
  } fa_result_t;

  function automatic fa_result_t fa_eval(input logic a, input logic b, input logic ci);
    fa_result_t r;
    r.sum  = a ^ b ^ ci;
    r.cout = (a & b) | (a & ci) | (b & ci);
    return r;
  endfunction
endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             en,
  input  logic             sin,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] shifted;

  generate
    if (WIDTH == 1) begin : g_single
      assign shifted = sin;
    end else begin : g_multi
      assign shifted = {sin, q[WIDTH-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (en)  q <= shifted;
  end
endmodule

// File: rtl/sa_full_adder.sv
module sa_full_adder
  import serial_add_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  fa_result_t r;
  always_comb r = fa_eval(a, b, ci);
  assign s  = r.sum;
  assign co = r.cout;
endmodule

// File: rtl/sa_carry_reg.sv
module sa_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (en)   q <= d;
  end
endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top
  import serial_add_pkg::*;
#(
  parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] acc_init,
  input  logic [WIDTH-1:0] addend_init,
  input  logic             step_en,
  input  logic             carry_clr,
  input  logic             addend_sin,
  output logic [WIDTH-1:0] acc_q,
  output logic [WIDTH-1:0] addend_q,
  output logic             carry_q,
  output logic             sum_bit
);
  logic fa_cout;
  // carry advances only on a real step, never on a load cycle
  logic carry_en;
  assign carry_en = step_en & ~load;

  sa_full_adder u_fa (
    .a  (acc_q[0]),
    .b  (addend_q[0]),
    .ci (carry_q),
    .s  (sum_bit),
    .co (fa_cout)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (load),
    .ld_val (acc_init),
    .en     (step_en),
    .sin    (sum_bit),
    .q      (acc_q)
  );

  sa_shift_reg #(.WIDTH(WIDTH)) u_addend (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (load),
    .ld_val (addend_init),
    .en     (step_en),
    .sin    (addend_sin),
    .q      (addend_q)
  );

  sa_carry_reg u_carry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (carry_clr),
    .en    (carry_en),
    .d     (fa_cout),
    .q     (carry_q)
  );
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [WIDTH-1:0] acc_init,
  input logic [WIDTH-1:0] addend_init,
  input logic             step_en,
  input logic             carry_clr,
  input logic             addend_sin,
  input logic [WIDTH-1:0] acc_q,
  input logic [WIDTH-1:0] addend_q,
  input logic             carry_q,
  input logic             sum_bit
);
  localparam logic [WIDTH-1:0] LOW_MASK = {WIDTH{1'b1}} >> 1;

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (acc_q == '0 && addend_q == '0 && !carry_q));

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load && !carry_clr |=> acc_q == $past(acc_init) && addend_q == $past(addend_init)
                          && carry_q == $past(carry_q));

  a_r3_acc_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !load && step_en |=> acc_q[WIDTH-1] == $past(sum_bit)
                        && (acc_q & LOW_MASK) == ($past(acc_q) >> 1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step_en && !carry_clr |=> $stable(acc_q) && $stable(addend_q) && $stable(carry_q));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    carry_clr |=> !carry_q);

  a_r7_addend_sin: assert property (@(posedge clk) disable iff (!rst_n)
    !load && step_en |=> addend_q[WIDTH-1] == $past(addend_sin)
                        && (addend_q & LOW_MASK) == ($past(addend_q) >> 1));

  always_comb begin
    if (rst_n) begin
      a_r8_sum_comb: assert (sum_bit == (acc_q[0] ^ addend_q[0] ^ carry_q));
    end
  end
endmodule

bind serial_adder_top serial_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/serial_adder_top_test.sv
module serial_adder_top_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] acc_init = '0;
  logic [W-1:0] addend_init = '0;
  logic         step_en = 1'b0;
  logic         carry_clr = 1'b0;
  logic         addend_sin = 1'b0;
  logic [W-1:0] acc_q;
  logic [W-1:0] addend_q;
  logic         carry_q;
  logic         sum_bit;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_adder_top #(.WIDTH(W)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: inputs already set at a negedge, wait for the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    load = 0; step_en = 0; carry_clr = 0; addend_sin = 0;
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b, input logic clr);
    load = 1; acc_init = a; addend_init = b; carry_clr = clr; step_en = 1;
    tick();
    idle();
  endtask

  task automatic run_steps(input int n, input logic [W-1:0] sin_bits);
    for (int i = 0; i < n; i++) begin
      step_en = 1; addend_sin = sin_bits[i];
      tick();
    end
    idle();
  endtask

  task automatic t_reset();
    check("R1 acc", acc_q, 0);
    check("R1 addend", addend_q, 0);
    check("R1 carry", carry_q, 0);
  endtask

  task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b);
    int full;
    full = a + b;
    do_load(a, b, 1'b1);
    check("R2 acc loaded", acc_q, a);
    check("R5 carry cleared with load", carry_q, 0);
    run_steps(W, 4'b0000);
    check("R6 sum", acc_q, full % (1 << W));
    check("R6 carry", carry_q, (full >> W) & 1);
  endtask

  task automatic t_carry_in();
    // leaves carry 1, then next add without clear
    t_add(4'b1011, 4'b0101);
    do_load(4'b0001, 4'b0001, 1'b0);
    check("R2 load keeps carry", carry_q, 1);
    run_steps(W, 4'b0000);
    check("R6 carry-in sum", acc_q, 3);
    check("R6 carry-in carry", carry_q, 0);
  endtask

  task automatic t_hold();
    do_load(4'b0111, 4'b0011, 1'b1);
    run_steps(2, 4'b0000);
    // after 2 steps: 7+3 low bits: sum bits 0,1 -> acc = {1,0,0,1}? computed below
    begin
      logic [W-1:0] a_mid;
      logic c_mid;
      a_mid = acc_q; c_mid = carry_q;
      for (int i = 0; i < 3; i++) tick();
      check("R4 acc hold", acc_q, a_mid);
      check("R4 carry hold", carry_q, c_mid);
      check("R4 addend hold", addend_q, 0);
    end
    run_steps(2, 4'b0000);
    check("R4 paused sum", acc_q, 10);
    check("R4 paused carry", carry_q, 0);
  endtask

  task automatic t_clear_priority();
    do_load(4'b1111, 4'b0001, 1'b1);
    step_en = 1; carry_clr = 1;
    tick();
    idle();
    check("R5 clear beats carry", carry_q, 0);
    check("R3 acc still shifts", acc_q, 4'b0111);
  endtask

  task automatic t_serial_b();
    do_load(4'b0000, 4'b0000, 1'b1);
    run_steps(W, 4'b0110);
    check("R7 streamed addend", addend_q, 4'b0110);
    do_load(4'b0000, 4'b1001, 1'b1);
    run_steps(1, 4'b0001);
    check("R7 one step", addend_q, 4'b1100);
  endtask

  task automatic t_sum_bit();
    do_load(4'b0011, 4'b0001, 1'b1);
    check("R8 sum bit 1+1", sum_bit, 0);
    do_load(4'b0010, 4'b0001, 1'b1);
    check("R8 sum bit 0+1", sum_bit, 1);
    step_en = 1;
    tick();
    idle();
    check("R3 sum bit shifted in", acc_q, 4'b1001);
    check("R3 carry after step", carry_q, 0);
  endtask

  initial begin
    #1;
    check("R1 acc in reset", acc_q, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_add(4'b1000, 4'b0101);
    t_add(4'b1011, 4'b0101);
    t_add(4'b1111, 4'b1111);
    t_add(4'b0110, 4'b0011);
    t_add(4'b1001, 4'b0111);
    t_carry_in();
    t_hold();
    t_clear_priority();
    t_serial_b();
    t_sum_bit();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule